// File: doc/BRIEF.md
# Latched Driver Fault Guard

This block protects a four-output stepper bridge. It watches two digital condition flags that the analog front end produces: one for winding overcurrent and one for substrate overheat. When either condition is seen, the block raises a single drive-kill signal that forces every phase output of the bridge off. It also enables the pull-down of an active-low, open-drain fault pin. Both conditions are sticky. Once set, they hold until the system is reset, either by the power-on reset or by a low pulse on the active-low reset pin.

The overcurrent flag rings at the start of every PWM chopping period, so it is not trusted for a short window after each period-start strobe. That window is a parameter counted in system clock cycles and restarts on every strobe. Both flags cross into the clock domain through a synchronizer chain of configurable depth. The strobe is delayed by the same depth, so the window masks exactly the flag samples that were taken during it. The overheat flag is never masked.

Top module: `drv_fault_guard`

## Requirements
- R1: While `por_i` is high or `rst_pin_n_i` is low, and in the cycle after reset is released, `drive_kill_o` and `fault_oe_o` are 0.
- R2: An overheat flag first sampled at clock edge E sets both outputs to 1 after edge E+2. The latency is SYNC_STAGES+1 edges, with output registering off.
- R3: An overcurrent flag sampled outside any blanking window sets both outputs to 1 with the same latency as R2. A single-cycle pulse is enough.
- R4: If a period-start strobe is sampled at edge T, overcurrent samples taken at edges T through T+BLANK_CYC-1 are ignored. A sample at edge T+BLANK_CYC trips the block.
- R5: A strobe that arrives while a window is running restarts the window at full length from that strobe.
- R6: Once set, the outputs stay at 1 after the flag that caused them has returned to 0.
- R7: A latched fault clears on the first edge at which `por_i` is high or `rst_pin_n_i` is low. Either reset source alone is sufficient.
- R8: Reset wins over a fault flag asserted in the same cycle. A flag held through reset sets the outputs SYNC_STAGES+1 edges after the first edge with reset released.
- R9: `fault_oe_o` (1 = pull the fault pin low) always equals `drive_kill_o`.
- R10: The overheat flag is never masked by the blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, sampled synchronously |
| rst_pin_n_i | input | 1 | Reset pin, active low, sampled synchronously |
| pwm_start_i | input | 1 | One-cycle strobe at the start of each chopping period |
| oc_flag_i | input | 1 | Overcurrent comparator flag, asynchronous |
| ot_flag_i | input | 1 | Overheat flag, asynchronous |
| drive_kill_o | output | 1 | 1 forces all four phase outputs off |
| fault_oe_o | output | 1 | 1 enables the open-drain pull-down of the fault pin |

## Verification
Every result of this block is due a fixed number of edges after its stimulus. A flag change shows at the outputs SYNC_STAGES+1 edges after it is sampled. A reset shows one edge after it is sampled. The bench stamps each expected value with the cycle in which it is due: the cycle count at the drive moment plus that latency. The monitor compares only in that cycle, and it samples just after the edge. The blanking tests place overcurrent pulses on the last masked sample and on the first unmasked sample after a strobe, and after a restarted window. This exposes an off-by-one in the window length or in the strobe alignment.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;

   // Sticky fault state, one bit per condition.
   typedef struct packed {
      logic oc;
      logic ot;
   } fault_vec_t;

   // Smallest synchronizer depth accepted for the condition flags.
   localparam int unsigned MIN_SYNC_STAGES = 2;

   // Width of a down-counter that must hold the value n.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/dfg_sync.sv
module dfg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   import drv_fault_pkg::*;

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
         $error("dfg_sync: STAGES below minimum synchronizer depth");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dfg_sync: WIDTH must be at least 1");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) stg_q[s] <= '0;
               else       stg_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) stg_q[s] <= '0;
               else       stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dfg_blank_timer.sv
module dfg_blank_timer #(
   parameter int unsigned BLANK_CYC = 1375,
   parameter int unsigned ALIGN     = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   output logic blank_o
);
   import drv_fault_pkg::*;

   localparam int unsigned CW = cnt_bits(BLANK_CYC);
   localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC - 1);

   logic          start_al;
   logic [CW-1:0] cnt_q;

   generate
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("dfg_blank_timer: BLANK_CYC must be at least 1");
      end

      // Delay the strobe by the flag synchronizer depth so the window
      // lines up with the samples taken while the bridge rings.
      if (ALIGN == 0) begin : g_no_align
         assign start_al = start_i;
      end else begin : g_align
         logic [ALIGN-1:0] dly_q;
         for (genvar k = 0; k < ALIGN; k++) begin : g_dly
            if (k == 0) begin : g_head
               always_ff @(posedge clk_i) begin
                  if (rst_i) dly_q[k] <= 1'b0;
                  else       dly_q[k] <= start_i;
               end
            end else begin : g_tail
               always_ff @(posedge clk_i) begin
                  if (rst_i) dly_q[k] <= 1'b0;
                  else       dly_q[k] <= dly_q[k-1];
               end
            end
         end
         assign start_al = dly_q[ALIGN-1];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)              cnt_q <= '0;
      else if (start_al)      cnt_q <= RELOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign blank_o = start_al | (cnt_q != '0);

   generate
      if (BLANK_CYC > 1) begin : g_chk
         // R5
         restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            start_al |=> blank_o)
            else $error("blanking window did not continue after a strobe");
      end
   endgenerate

endmodule

// File: rtl/dfg_fault_latch.sv
module dfg_fault_latch (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      oc_hit_i,
   input  logic                      ot_hit_i,
   output drv_fault_pkg::fault_vec_t lat_o
);
   import drv_fault_pkg::*;

   fault_vec_t lat_q;

   // Reset has priority: a hit in a reset cycle is dropped.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lat_q <= '0;
      end else begin
         lat_q.oc <= lat_q.oc | oc_hit_i;
         lat_q.ot <= lat_q.ot | ot_hit_i;
      end
   end

   assign lat_o = lat_q;

   // R6
   sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (lat_q.oc || lat_q.ot) |=> (lat_q.oc || lat_q.ot))
      else $error("latched fault dropped without reset");

   // R8
   rst_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (!lat_q.oc && !lat_q.ot))
      else $error("fault state survived a reset cycle");

   // R2
   ot_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ot_hit_i |=> lat_q.ot)
      else $error("overheat hit did not latch");

endmodule

// File: rtl/drv_fault_guard.sv
module drv_fault_guard #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BLANK_CYC   = 1375,
   parameter bit          OUT_REG     = 1'b0
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic rst_pin_n_i,
   input  logic pwm_start_i,
   input  logic oc_flag_i,
   input  logic ot_flag_i,
   output logic drive_kill_o,
   output logic fault_oe_o
);
   import drv_fault_pkg::*;

   localparam int unsigned FLAG_W = 2;

   logic              sys_rst;
   logic [FLAG_W-1:0] flag_raw;
   logic [FLAG_W-1:0] flag_s;
   logic              blank;
   logic              oc_hit;
   logic              ot_hit;
   fault_vec_t        lat;
   logic              any_fault;

   assign sys_rst  = por_i | ~rst_pin_n_i;
   assign flag_raw = {oc_flag_i, ot_flag_i};

   dfg_sync #(
      .WIDTH  (FLAG_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i (clk_i),
      .rst_i (sys_rst),
      .d_i   (flag_raw),
      .q_o   (flag_s)
   );

   dfg_blank_timer #(
      .BLANK_CYC (BLANK_CYC),
      .ALIGN     (SYNC_STAGES)
   ) u_blank (
      .clk_i   (clk_i),
      .rst_i   (sys_rst),
      .start_i (pwm_start_i),
      .blank_o (blank)
   );

   assign oc_hit = flag_s[1] & ~blank;
   assign ot_hit = flag_s[0];

   dfg_fault_latch u_latch (
      .clk_i    (clk_i),
      .rst_i    (sys_rst),
      .oc_hit_i (oc_hit),
      .ot_hit_i (ot_hit),
      .lat_o    (lat)
   );

   assign any_fault = lat.oc | lat.ot;

   generate
      if (OUT_REG) begin : g_out_reg
         logic kill_q;
         always_ff @(posedge clk_i) begin
            if (sys_rst) kill_q <= 1'b0;
            else         kill_q <= any_fault;
         end
         assign drive_kill_o = kill_q;
         assign fault_oe_o   = kill_q;
      end else begin : g_out_comb
         assign drive_kill_o = any_fault;
         assign fault_oe_o   = any_fault;
      end
   endgenerate

   // R4
   blank_mask_chk: assert property (@(posedge clk_i) disable iff (sys_rst)
      $rose(lat.oc) |-> $past(!blank))
      else $error("overcurrent latched from a blanked sample");

   // R10
   ot_unmasked_chk: assert property (@(posedge clk_i) disable iff (sys_rst)
      (flag_s[0] && blank) |=> lat.ot)
      else $error("overheat suppressed during blanking");

endmodule

// File: tb/drv_fault_guard_tb.sv
module drv_fault_guard_tb;

   localparam int unsigned SYNC  = 2;
   localparam int unsigned BLANK = 12;
   localparam int          LAT   = SYNC + 1;

   typedef struct {
      int    due;
      logic  val;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic rst_n = 1'b1;
   logic strobe = 1'b0;
   logic oc = 1'b0;
   logic ot = 1'b0;
   logic kill;
   logic oe;

   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   drv_fault_guard #(
      .SYNC_STAGES (SYNC),
      .BLANK_CYC   (BLANK),
      .OUT_REG     (1'b0)
   ) u_dut (
      .clk_i        (clk),
      .por_i        (por),
      .rst_pin_n_i  (rst_n),
      .pwm_start_i  (strobe),
      .oc_flag_i    (oc),
      .ot_flag_i    (ot),
      .drive_kill_o (kill),
      .fault_oe_o   (oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver side: push the value due off cycles after the current count.
   task automatic expect_at(input int off, input logic v, input string r);
      exp_t e;
      e.due = cyc + off;
      e.val = v;
      e.req = r;
      q.push_back(e);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   // Monitor: pop every item due in this cycle and compare just after the edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (e.due != cyc || kill !== e.val) begin
               n_bad++;
               $display("FAIL %s drive_kill cyc=%0d due=%0d actual=%b expected=%b",
                        e.req, cyc, e.due, kill, e.val);
            end
            n_cmp++;
            if (oe !== kill) begin
               n_bad++;
               $display("FAIL R9 fault_oe cyc=%0d actual=%b expected=%b", cyc, oe, kill);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   task automatic por_pulse();
      por = 1'b1;
      expect_at(1, 1'b0, "R7");
      tick(1);
      por = 1'b0;
      tick(3);
   endtask

   initial begin
      tick(3);
      // R1: reset state
      por = 1'b0;
      expect_at(1, 1'b0, "R1");
      expect_at(2, 1'b0, "R1");
      tick(4);

      // R2 latency, R6 stickiness
      ot = 1'b1;
      expect_at(LAT - 1, 1'b0, "R2");
      expect_at(LAT, 1'b1, "R2");
      tick(1);
      ot = 1'b0;
      expect_at(9, 1'b1, "R6");
      tick(10);

      // R7: pin pulse clears
      rst_n = 1'b0;
      expect_at(1, 1'b0, "R7");
      tick(1);
      rst_n = 1'b1;
      expect_at(4, 1'b0, "R7");
      tick(5);

      // R4: overcurrent held across the whole window is ignored
      strobe = 1'b1;
      oc = 1'b1;
      expect_at(3, 1'b0, "R4");
      expect_at(BLANK, 1'b0, "R4");
      expect_at(BLANK + 4, 1'b0, "R4");
      tick(1);
      strobe = 1'b0;
      tick(BLANK - 1);
      oc = 1'b0;
      tick(8);

      // R4: first sample after the window trips
      strobe = 1'b1;
      tick(1);
      strobe = 1'b0;
      tick(BLANK - 1);
      oc = 1'b1;
      expect_at(LAT - 1, 1'b0, "R4");
      expect_at(LAT, 1'b1, "R4");
      tick(1);
      oc = 1'b0;
      tick(5);
      por_pulse();

      // R5: a second strobe restarts the window
      strobe = 1'b1;
      tick(1);
      strobe = 1'b0;
      tick(5);
      strobe = 1'b1;
      tick(1);
      strobe = 1'b0;
      tick(7);
      oc = 1'b1;
      expect_at(LAT, 1'b0, "R5");
      tick(1);
      oc = 1'b0;
      tick(3);
      oc = 1'b1;
      expect_at(LAT - 1, 1'b0, "R5");
      expect_at(LAT, 1'b1, "R5");
      tick(1);
      oc = 1'b0;
      tick(4);
      por_pulse();

      // R3: single-cycle overcurrent with no window running
      tick(20);
      oc = 1'b1;
      expect_at(LAT - 1, 1'b0, "R3");
      expect_at(LAT, 1'b1, "R3");
      tick(1);
      oc = 1'b0;
      expect_at(6, 1'b1, "R6");
      tick(7);
      rst_n = 1'b0;
      expect_at(1, 1'b0, "R7");
      tick(1);
      rst_n = 1'b1;
      tick(3);

      // R10: overheat is not blanked
      strobe = 1'b1;
      ot = 1'b1;
      expect_at(LAT, 1'b1, "R10");
      tick(1);
      strobe = 1'b0;
      ot = 1'b0;
      tick(4);
      por_pulse();

      // R8: reset beats a simultaneous flag, flag held re-trips after release
      rst_n = 1'b0;
      ot = 1'b1;
      expect_at(1, 1'b0, "R8");
      expect_at(3, 1'b0, "R8");
      tick(3);
      rst_n = 1'b1;
      expect_at(LAT - 1, 1'b0, "R8");
      expect_at(LAT, 1'b1, "R8");
      tick(4);
      ot = 1'b0;
      por_pulse();

      while (q.size() > 0) tick(1);
      tick(2);
      summary();
      $finish;
   end

endmodule